// File: doc/BRIEF.md
# Big-Endian Byte/Word Load-Store Lane Unit

This block sits between a 32-bit register datapath and a word-organized data memory. The memory is addressed in bytes, and each 32-bit word holds four consecutive byte addresses. The block takes a byte address that has already been computed (a base register value plus a signed 16-bit offset). It turns each access into a word address for memory, a read strobe, a write word and four byte enables. For loads, it shapes the word that comes back from memory into a register result.

The block supports four operations: word load, word store, byte load and byte store. Bytes are numbered big-endian, so the byte at a word's own address is the most significant byte. A byte load picks one lane and sign-extends it. A byte store copies its byte onto every lane and enables only the addressed lane. The rest of that word keeps its old contents. A word access whose address is not a multiple of 4 is flagged as misaligned and has no effect on memory.

Memory has one cycle of read latency. The store outputs are combinational in the request cycle. The load result is valid in the cycle after the request.

Top module: `be_lane_lsu`

## Requirements
- R1: The operation code on `accOp` is 00 word load, 01 word store, 10 byte load, 11 byte store. An aligned word load raises `memRead` in the request cycle with `memAddr` = byte address with bits 1:0 cleared. In the next cycle it raises `loadValid`, and `loadData` equals `memRdData` unchanged.
- R2: An aligned word store drives `memByteEn` = 4'b1111 and `memWrData` = `storeData` in the request cycle.
- R3: A word load or store whose address bits 1:0 are nonzero raises `misaligned` in the request cycle. It drives `memByteEn` = 0 and `memRead` = 0, and no `loadValid` follows.
- R4: Lanes are big-endian. Address offset 0 selects memory word bits 31:24, offset 1 selects 23:16, offset 2 selects 15:8 and offset 3 selects 7:0. For a byte load, the selected byte appears in `loadData[7:0]` one cycle after the request.
- R5: A byte load fills `loadData[31:8]` with bit 7 of the selected byte.
- R6: A byte store drives exactly one enable: `memByteEn[3]` for offset 0, `[2]` for offset 1, `[1]` for offset 2 and `[0]` for offset 3. It places `storeData[7:0]` on all four lanes of `memWrData`. The other three bytes of the memory word keep their values.
- R7: Byte accesses at any offset never raise `misaligned`.
- R8: `loadValid` is high exactly in the cycle after an accepted load, and only then. While `accValid` is low, `memRead`, `memByteEn` and `misaligned` are all zero.
- R9: While `rstN` is low, `loadValid`, `misaligned` and `memByteEn` are zero when no access is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accOp | input | 2 | Operation: 00 word load, 01 word store, 10 byte load, 11 byte store |
| byteAddr | input | 32 | Effective byte address |
| storeData | input | 32 | Register value to store |
| memRdData | input | 32 | Word returned by memory one cycle after `memRead` |
| memAddr | output | 32 | Word-aligned memory address |
| memRead | output | 1 | Memory read strobe |
| memWrData | output | 32 | Memory write word |
| memByteEn | output | 4 | Per-byte write enables, bit 3 = bits 31:24 |
| loadData | output | 32 | Load result, zero when not valid |
| loadValid | output | 1 | Load result valid |
| misaligned | output | 1 | Word access on a non-multiple-of-4 address |

## Verification
The bench targets four kinds of error. It runs byte loads and byte stores at all four offsets: a design that used little-endian numbering would return the wrong byte and enable the mirrored lane. It reads bytes whose top bit is set, which exposes zero-extension. After a series of byte stores it reads back whole words, which catches a store that overwrites neighbouring lanes. Word accesses at offsets 1 to 3 are followed by idle cycles, so a stray write enable, read strobe or result pulse is seen at the ports.

// File: rtl/be_lane_pkg.sv
package be_lane_pkg;
  localparam int DATA_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int NUM_LANES = DATA_W / BYTE_W;
  localparam int LANE_W    = $clog2(NUM_LANES);

  typedef enum logic [1:0] {
    OP_LOAD_WORD  = 2'b00,
    OP_STORE_WORD = 2'b01,
    OP_LOAD_BYTE  = 2'b10,
    OP_STORE_BYTE = 2'b11
  } accOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              readEn;   // accepted load this cycle
    logic              wordWr;   // aligned word store
    logic              byteWr;   // byte store
    logic [LANE_W-1:0] lane;     // byte offset of request
    logic              rspValid; // load result cycle
    logic              rspByte;  // result is a byte load
    logic [LANE_W-1:0] rspLane;  // offset of the pending byte load
  } laneStrobe_t;
endpackage

// File: rtl/be_lane_ctrl.sv
module be_lane_ctrl
  import be_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  accOp_e            accOp,
  input  logic [LANE_W-1:0] laneSel,
  output laneStrobe_t       strb,
  output logic              misaligned
);
  logic isWord;
  logic isLoad;
  logic misal;
  logic rspValidQ;
  logic rspByteQ;
  logic [LANE_W-1:0] rspLaneQ;

  always_comb begin
    isWord = (accOp == OP_LOAD_WORD) || (accOp == OP_STORE_WORD);
    isLoad = (accOp == OP_LOAD_WORD) || (accOp == OP_LOAD_BYTE);
    misal  = accValid && isWord && (laneSel != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValidQ <= 1'b0;
      rspByteQ  <= 1'b0;
      rspLaneQ  <= '0;
    end else begin
      rspValidQ <= accValid && isLoad && !misal;
      rspByteQ  <= (accOp == OP_LOAD_BYTE);
      rspLaneQ  <= laneSel;
    end
  end

  always_comb begin
    strb.readEn   = accValid && isLoad && !misal;
    strb.wordWr   = accValid && (accOp == OP_STORE_WORD) && !misal;
    strb.byteWr   = accValid && (accOp == OP_STORE_BYTE);
    strb.lane     = laneSel;
    strb.rspValid = rspValidQ;
    strb.rspByte  = rspByteQ;
    strb.rspLane  = rspLaneQ;
    misaligned    = misal;
  end

  // R7: byte operations never flag misalignment
  a_r7_byte_never_misaligned: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (accOp == OP_LOAD_BYTE || accOp == OP_STORE_BYTE)) |-> !misaligned);

  // R3: a flagged access starts no read and no write
  a_r3_misal_inert: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (!strb.readEn && !strb.wordWr && !strb.byteWr));
endmodule

// File: rtl/be_lane_datapath.sv
module be_lane_datapath
  import be_lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       strb,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRead,
  output logic [DATA_W-1:0] memWrData,
  output logic [NUM_LANES-1:0] memByteEn,
  output logic [DATA_W-1:0] loadData,
  output logic              loadValid
);
  localparam int EXT_W = DATA_W - BYTE_W;

  logic [BYTE_W-1:0] rdByte [NUM_LANES];
  logic [BYTE_W-1:0] pickByte;

  assign memAddr = {byteAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign memRead = strb.readEn;

  // Lane g sits at bits DATA_W-1-g*BYTE_W downward (big-endian)
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int HI = DATA_W - 1 - g * BYTE_W;
    always_comb begin
      memByteEn[NUM_LANES-1-g] = strb.wordWr ||
                                 (strb.byteWr && (strb.lane == LANE_W'(g)));
      if (strb.wordWr)
        memWrData[HI -: BYTE_W] = storeData[HI -: BYTE_W];
      else if (strb.byteWr)
        memWrData[HI -: BYTE_W] = storeData[BYTE_W-1:0];
      else
        memWrData[HI -: BYTE_W] = '0;
      rdByte[g] = memRdData[HI -: BYTE_W];
    end
  end

  assign pickByte  = rdByte[strb.rspLane];
  assign loadValid = strb.rspValid;

  always_comb begin
    if (!strb.rspValid)
      loadData = '0;
    else if (strb.rspByte)
      loadData = {{EXT_W{pickByte[BYTE_W-1]}}, pickByte};
    else
      loadData = memRdData;
  end

  // R6: a byte store enables exactly one lane
  a_r6_single_lane: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteWr |-> ($countones(memByteEn) == 1));

  // R2: a word store enables every lane and passes the word
  a_r2_full_word: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordWr |-> ((&memByteEn) && memWrData == storeData));

  // R5: upper result bits copy the byte's sign
  a_r5_sign_fill: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && strb.rspByte) |-> (loadData[DATA_W-1:BYTE_W] == {EXT_W{loadData[BYTE_W-1]}}));
endmodule

// File: rtl/be_lane_lsu.sv
module be_lane_lsu
  import be_lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [1:0]        accOp,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [31:0]       storeData,
  input  logic [31:0]       memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRead,
  output logic [31:0]       memWrData,
  output logic [3:0]        memByteEn,
  output logic [31:0]       loadData,
  output logic              loadValid,
  output logic              misaligned
);
  laneStrobe_t strb;

  be_lane_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .accValid  (accValid),
    .accOp     (accOp_e'(accOp)),
    .laneSel   (byteAddr[LANE_W-1:0]),
    .strb      (strb),
    .misaligned(misaligned)
  );

  be_lane_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .byteAddr (byteAddr),
    .storeData(storeData),
    .memRdData(memRdData),
    .memAddr  (memAddr),
    .memRead  (memRead),
    .memWrData(memWrData),
    .memByteEn(memByteEn),
    .loadData (loadData),
    .loadValid(loadValid)
  );

  // R8: no activity while no access is presented
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (memByteEn == '0 && !memRead && !misaligned));

  // R8: a result only follows a read strobe
  a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(memRead));

  // R3: misaligned word access leaves memory alone
  a_r3_no_enable: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (memByteEn == '0 && !memRead));
endmodule

// File: tb/be_lane_lsu_tb.sv
`timescale 1ns/1ps
module be_lane_lsu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [1:0]  accOp = 2'b00;
  logic [31:0] byteAddr = '0;
  logic [31:0] storeData = '0;
  logic [31:0] memRdData = '0;
  logic [31:0] memAddr;
  logic        memRead;
  logic [31:0] memWrData;
  logic [3:0]  memByteEn;
  logic [31:0] loadData;
  logic        loadValid;
  logic        misaligned;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] memB [64];
  logic [7:0] refB [64];
  logic [31:0] expQ [$];

  always #4 clk = ~clk;

  be_lane_lsu u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accOp(accOp),
    .byteAddr(byteAddr), .storeData(storeData), .memRdData(memRdData),
    .memAddr(memAddr), .memRead(memRead), .memWrData(memWrData),
    .memByteEn(memByteEn), .loadData(loadData), .loadValid(loadValid),
    .misaligned(misaligned)
  );

  // memory model: big-endian, one cycle read latency
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (memByteEn[3-k]) memB[{memAddr[5:2], 2'(k)}] <= memWrData[31-8*k -: 8];
    if (memRead)
      memRdData <= {memB[{memAddr[5:2], 2'd0}], memB[{memAddr[5:2], 2'd1}],
                    memB[{memAddr[5:2], 2'd2}], memB[{memAddr[5:2], 2'd3}]};
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", cycles, 0);
      summary();
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && loadValid) begin
      if (expQ.size() == 0)
        chk(1'b0, "R8 unexpected loadValid", loadData, 32'h0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        chk(loadData === e, "R1/R4/R5 load result", loadData, e);
      end
    end
  end

  function automatic logic [31:0] refWord(input logic [5:0] a);
    return {refB[{a[5:2], 2'd0}], refB[{a[5:2], 2'd1}], refB[{a[5:2], 2'd2}], refB[{a[5:2], 2'd3}]};
  endfunction

  // driver: presents one access for one cycle
  task automatic acc(input logic [1:0] op, input logic [5:0] a, input logic [31:0] sd);
    logic [3:0] en;
    accValid = 1'b1; accOp = op; byteAddr = {26'd0, a}; storeData = sd;
    #1;
    case (op)
      2'b00: if (a[1:0] != 0) begin
               chk(misaligned === 1'b1, "R3 word load flag", {31'd0, misaligned}, 32'd1);
               chk(!memRead && memByteEn == 0, "R3 word load inert", {27'd0, memRead, memByteEn}, 32'd0);
             end else begin
               chk(memRead === 1'b1 && memAddr == {26'd0, a}, "R1 read strobe/addr", memAddr, {26'd0, a});
               expQ.push_back(refWord(a));
             end
      2'b01: if (a[1:0] != 0) begin
               chk(misaligned === 1'b1 && memByteEn == 0, "R3 word store", {27'd0, misaligned, memByteEn}, 32'h10);
             end else begin
               chk(memByteEn == 4'hF && memWrData == sd, "R2 word store", memWrData, sd);
               for (int k = 0; k < 4; k++) refB[{a[5:2], 2'(k)}] = sd[31-8*k -: 8];
             end
      2'b10: begin
               chk(misaligned === 1'b0 && memRead === 1'b1, "R7 byte load not misaligned", {31'd0, misaligned}, 32'd0);
               expQ.push_back({{24{refB[a][7]}}, refB[a]});
             end
      default: begin
               en = 4'b1000 >> a[1:0];
               chk(misaligned === 1'b0, "R7 byte store not misaligned", {31'd0, misaligned}, 32'd0);
               chk(memByteEn == en, "R6 byte enable lane", {28'd0, memByteEn}, {28'd0, en});
               chk(memWrData == {4{sd[7:0]}}, "R6 replicated data", memWrData, {4{sd[7:0]}});
               refB[a] = sd[7:0];
             end
    endcase
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    accValid = 1'b0;
    #1;
    chk(!memRead && memByteEn == 0 && !misaligned, "R8 idle quiet", {27'd0, memRead, memByteEn}, 32'd0);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      memB[i] = 8'((i * 37 + 5) ^ (i << 5));
      refB[i] = 8'((i * 37 + 5) ^ (i << 5));
    end
    repeat (3) @(negedge clk);
    chk(!loadValid && !misaligned && memByteEn == 0, "R9 reset state", {27'd0, loadValid, memByteEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 word loads, back to back
    acc(2'b00, 6'd0, 0); acc(2'b00, 6'd4, 0); acc(2'b00, 6'd60, 0);
    idle(1);
    // R4 R5 byte loads at every offset in two words
    for (int o = 0; o < 8; o++) acc(2'b10, 6'(8 + o), 0);
    idle(1);
    // R3 misaligned word accesses, each followed by idle
    for (int o = 1; o < 4; o++) begin
      acc(2'b00, 6'(16 + o), 0); idle(2);
      acc(2'b01, 6'(16 + o), 32'hDEADBEEF); idle(1);
    end
    acc(2'b00, 6'd16, 0); idle(1); // R3 word untouched
    // R2 word store then readback
    acc(2'b01, 6'd20, 32'h1234_80FF); acc(2'b00, 6'd20, 0);
    // R6 byte stores per lane, readback of whole words
    acc(2'b01, 6'd24, 32'hA5A5_A5A5);
    acc(2'b11, 6'd24, 32'hFFFF_FF11); acc(2'b00, 6'd24, 0);
    acc(2'b11, 6'd25, 32'h0000_0082); acc(2'b00, 6'd24, 0);
    acc(2'b11, 6'd26, 32'h0000_0033); acc(2'b00, 6'd24, 0);
    acc(2'b11, 6'd27, 32'h0000_00C4); acc(2'b00, 6'd24, 0);
    for (int o = 0; o < 4; o++) acc(2'b10, 6'(24 + o), 0); // R5 signs
    idle(4);
    chk(expQ.size() == 0, "R8 all loads answered", expQ.size(), 0);
    summary();
  end
endmodule